// File: doc/BRIEF.md
# Pointer-Addressed Buffer RAM Port

This block lets a host processor reach a 2048-byte internal buffer through a window of only three byte-wide registers. Two registers hold an 11-bit RAM pointer and its mode bits. The third is a data register, and it is the only path to RAM contents. The host first loads the pointer. It then moves bytes through the data register, one by one, either at a fixed location or with the pointer stepping after each access.

Host reads never wait. When the host writes the low pointer byte with the read direction selected, the block fetches the addressed byte into the data register at once. In auto-increment read mode, each data read also fetches the following byte. A host write to the data register is held in that register and stored to RAM on the next clock. The host must leave at least one idle clock between strobes. That gap leaves room for the single RAM port to finish a fetch or a commit before the next access.

Top module: `bufport_top`

## Requirements
- R1: After synchronous reset, the pointer, the mode bits and the data register all read as zero.
- R2: The select codes are 0 for pointer-high, 1 for pointer-low, 2 for data and 3 for nothing. Pointer-high bit 7 is the direction (1 = read, 0 = write). Bit 6 enables auto-increment. Bits 2:0 are pointer bits 10:8, and bits 5:3 read as zero. Pointer-low holds pointer bits 7:0.
- R3: Writing pointer-low while the direction is read fetches RAM at the new pointer into the data register. The byte is readable at the next allowed strobe.
- R4: With auto-increment off, repeated data reads return the same byte and leave the pointer unchanged.
- R5: A data-register write latches the byte, reads back at once from the data register, and is stored to RAM at the current pointer on the following clock.
- R6: With auto-increment on and the direction set to read, each data read returns the current byte, advances the pointer by one and fetches the next byte.
- R7: With auto-increment on, each data write stores at the old pointer, and the pointer then advances by one.
- R8: The pointer wraps from 2047 to 0.
- R9: Writing pointer-low with the direction set to write performs no fetch. A data read with the direction set to write does not move the pointer.
- R10: Select code 3 reads as zero and ignores writes. The read bus is zero whenever no read strobe is active.
- R11: Register reads complete in the strobe cycle itself, with no wait state. Strobes are one-hot and separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select code |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid during the read strobe cycle |

## Verification
A register read is due combinationally in the same cycle as its strobe. The bench samples it at the falling edge inside that strobe cycle. A fetched byte lands in the data register two rising edges after the pointer-low write or auto-increment read. A written byte reaches RAM one edge after the data write. The driver leaves two idle cycles after every strobe, so each queued expectation is compared only after the result it names is due.

// File: rtl/bufport_pkg.sv
package bufport_pkg;

    parameter int unsigned ADDR_W = 11;
    parameter int unsigned DATA_W = 8;

    localparam int unsigned HI_W     = ADDR_W - DATA_W;
    localparam int unsigned DIR_BIT  = DATA_W - 1;
    localparam int unsigned AUTO_BIT = DATA_W - 2;

    typedef enum logic [1:0] {
        SEL_PHI  = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_WRITE = 2'd2
    } ram_op_e;

    typedef struct packed {
        sel_e              sel;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic rd_dir;
        logic auto_inc;
    } mode_t;

    typedef struct packed {
        ram_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ram_cmd_t;

    function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/bufport_ram.sv
module bufport_ram
    import bufport_pkg::*;
(
    input  logic              clk,
    input  ram_cmd_t          cmd,
    output logic [DATA_W-1:0] q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cmd.op == OP_WRITE) begin
            mem[cmd.addr] <= cmd.wdata;
        end
        if (cmd.op == OP_FETCH) begin
            q <= mem[cmd.addr];
        end
    end
endmodule

// File: rtl/bufport_ptr.sv
module bufport_ptr
    import bufport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    output logic [ADDR_W-1:0] ptr_q,
    output mode_t             mode_q,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic wr_hi, wr_lo, rd_dat, wr_dat, step_rd, step_wr;

    always_comb begin
        wr_hi   = req.wr && (req.sel == SEL_PHI);
        wr_lo   = req.wr && (req.sel == SEL_PLO);
        rd_dat  = req.rd && (req.sel == SEL_DATA);
        wr_dat  = req.wr && (req.sel == SEL_DATA);
        step_rd = rd_dat && mode_q.auto_inc && mode_q.rd_dir;
        step_wr = wr_dat && mode_q.auto_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            mode_q <= '0;
        end else if (wr_hi) begin
            mode_q.rd_dir              <= req.wdata[DIR_BIT];
            mode_q.auto_inc            <= req.wdata[AUTO_BIT];
            ptr_q[ADDR_W-1:DATA_W]     <= req.wdata[HI_W-1:0];
        end else if (wr_lo) begin
            ptr_q[DATA_W-1:0]          <= req.wdata;
        end else if (step_rd || step_wr) begin
            ptr_q                      <= ptr_step(ptr_q);
        end
    end

    always_comb begin
        fetch_go   = (wr_lo && mode_q.rd_dir) || step_rd;
        fetch_addr = wr_lo ? {ptr_q[ADDR_W-1:DATA_W], req.wdata} : ptr_step(ptr_q);
    end
endmodule

// File: rtl/bufport_data.sv
module bufport_data
    import bufport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic [ADDR_W-1:0] ptr_q,
    input  logic              fetch_go,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] data_q,
    output ram_cmd_t          ram_cmd
);
    logic              commit_pend;
    logic [ADDR_W-1:0] commit_addr;
    logic              cap_pend;
    logic              wr_dat;

    assign wr_dat = req.wr && (req.sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            commit_pend <= 1'b0;
            commit_addr <= '0;
            cap_pend    <= 1'b0;
        end else begin
            cap_pend <= fetch_go;
            if (wr_dat) begin
                data_q      <= req.wdata;
                commit_pend <= 1'b1;
                commit_addr <= ptr_q;
            end else begin
                commit_pend <= 1'b0;
                if (cap_pend) begin
                    data_q <= ram_q;
                end
            end
        end
    end

    always_comb begin
        ram_cmd.op    = OP_IDLE;
        ram_cmd.addr  = commit_addr;
        ram_cmd.wdata = data_q;
        if (commit_pend) begin
            ram_cmd.op = OP_WRITE;
        end else if (fetch_go) begin
            ram_cmd.op   = OP_FETCH;
            ram_cmd.addr = fetch_addr;
        end
    end
endmodule

// File: rtl/bufport_top.sv
module bufport_top
    import bufport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  host_sel,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata
);
    host_req_t         req;
    logic [ADDR_W-1:0] ptr_q;
    mode_t             mode_q;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ram_q;
    ram_cmd_t          ram_cmd;
    logic [DATA_W-1:0] hi_view;

    always_comb begin
        req.sel   = sel_e'(host_sel);
        req.rd    = host_rd;
        req.wr    = host_wr;
        req.wdata = host_wdata;
    end

    bufport_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ptr_q      (ptr_q),
        .mode_q     (mode_q),
        .fetch_go   (fetch_go),
        .fetch_addr (fetch_addr)
    );

    bufport_data u_data (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ptr_q      (ptr_q),
        .fetch_go   (fetch_go),
        .fetch_addr (fetch_addr),
        .ram_q      (ram_q),
        .data_q     (data_q),
        .ram_cmd    (ram_cmd)
    );

    bufport_ram u_ram (
        .clk (clk),
        .cmd (ram_cmd),
        .q   (ram_q)
    );

    always_comb begin
        hi_view           = '0;
        hi_view[DIR_BIT]  = mode_q.rd_dir;
        hi_view[AUTO_BIT] = mode_q.auto_inc;
        hi_view[HI_W-1:0] = ptr_q[ADDR_W-1:DATA_W];
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (req.sel)
                SEL_PHI:  host_rdata = hi_view;
                SEL_PLO:  host_rdata = ptr_q[DATA_W-1:0];
                SEL_DATA: host_rdata = data_q;
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bufport_chk.sv
module bufport_chk
    import bufport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        host_sel,
    input logic              host_rd,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic [ADDR_W-1:0] ptr_q,
    input mode_t             mode_q,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] ram_q,
    input ram_cmd_t          ram_cmd
);
    logic rd_dat, wr_dat, wr_lo;
    assign rd_dat = host_rd && (host_sel == 2'd2);
    assign wr_dat = host_wr && (host_sel == 2'd2);
    assign wr_lo  = host_wr && (host_sel == 2'd1);

    // R10: bus is quiet without a read strobe
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> host_rdata == 8'h00);

    // R11: strobes never overlap
    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_wr));

    // R5: the written byte reaches RAM one clock later at the old pointer
    p_commit_r5: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> (ram_cmd.op == OP_WRITE) && (ram_cmd.wdata == $past(host_wdata))
                   && (ram_cmd.addr == $past(ptr_q)));

    // R3: the fetched byte lands in the data register
    p_prefetch_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && mode_q.rd_dir) |=> ##1 (data_q == $past(ram_q)));

    // R4: fixed-pointer reads change nothing
    p_fixed_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && !mode_q.auto_inc) |=> $stable(ptr_q) && $stable(data_q));

    // R6: auto-increment read steps the pointer
    p_auto_step_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && mode_q.auto_inc && mode_q.rd_dir) |=> ptr_q == ADDR_W'($past(ptr_q) + 1));

    // R8: pointer wraps at the top of RAM
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && mode_q.auto_inc && (&ptr_q)) |=> ptr_q == '0);

    // R9: no fetch in write direction
    p_no_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !mode_q.rd_dir) |=> $stable(data_q) ##1 $stable(data_q));
endmodule

bind bufport_top bufport_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ptr_q      (ptr_q),
    .mode_q     (mode_q),
    .data_q     (data_q),
    .ram_q      (ram_q),
    .ram_cmd    (ram_cmd)
);

// File: tb/tb_bufport_top.sv
`timescale 1ns/1ps
module tb_bufport_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] host_sel;
    logic       host_rd;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    bufport_top dut (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 8'hFF);
    endfunction

    // monitor: pops one expectation per read strobe
    always @(negedge clk) begin
        if (!rst && host_rd) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %02h expected none", host_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic do_wr(input logic [1:0] sel, input logic [7:0] val);
        @(posedge clk); #1;
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
        @(posedge clk);
    endtask

    task automatic do_rd(input logic [1:0] sel, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        host_sel = sel; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
        @(posedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1'b1; host_sel = 2'd0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        do_rd(2'd0, 8'h00, "R1 ptr-high");
        do_rd(2'd1, 8'h00, "R1 ptr-low");
        do_rd(2'd2, 8'h00, "R1 data");

        // R10 unused select and idle bus
        do_wr(2'd3, 8'hFF);
        do_rd(2'd3, 8'h00, "R10 unused select");
        do_rd(2'd0, 8'h00, "R10 write to select 3 ignored");
        @(negedge clk);
        n_run++;
        if (host_rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R10 idle bus: actual %02h expected 00", host_rdata);
        end

        // R7 auto-increment fill, write direction
        do_wr(2'd0, 8'h40);
        do_wr(2'd1, 8'h10);
        for (int a = 16'h10; a < 16'h18; a++) do_wr(2'd2, pat(a));
        do_rd(2'd1, 8'h18, "R7 pointer advanced by writes");
        do_rd(2'd0, 8'h40, "R2 mode bits readback");

        // R2 format: bits 5:3 read zero
        do_wr(2'd0, 8'hBD);
        do_rd(2'd0, 8'h85, "R2 ptr-high format");

        // R3/R4 fixed-pointer prefetch
        do_wr(2'd0, 8'h80);
        do_wr(2'd1, 8'h12);
        do_rd(2'd2, pat(16'h12), "R3 prefetch on ptr-low write");
        do_rd(2'd2, pat(16'h12), "R4 repeated read same byte");
        do_rd(2'd2, pat(16'h12), "R4 repeated read same byte");
        do_rd(2'd1, 8'h12, "R4 pointer fixed");

        // R6 auto-increment read, R11 zero-wait back-to-back data
        do_wr(2'd0, 8'hC0);
        do_wr(2'd1, 8'h10);
        for (int a = 16'h10; a < 16'h18; a++) do_rd(2'd2, pat(a), "R6 R11 sequential read");
        do_rd(2'd1, 8'h18, "R6 pointer after reads");

        // R5 fixed-pointer write
        do_wr(2'd0, 8'h00);
        do_wr(2'd1, 8'h30);
        do_wr(2'd2, 8'h5A);
        do_rd(2'd1, 8'h30, "R5 pointer unchanged on fixed write");
        do_rd(2'd2, 8'h5A, "R5 data register latched");
        do_wr(2'd0, 8'h80);
        do_wr(2'd1, 8'h30);
        do_rd(2'd2, 8'h5A, "R5 byte committed to RAM");

        // R9 write direction does not fetch or step
        do_wr(2'd0, 8'h00);
        do_wr(2'd1, 8'h12);
        do_rd(2'd2, 8'h5A, "R9 no fetch in write direction");
        do_wr(2'd0, 8'h40);
        do_rd(2'd2, 8'h5A, "R9 data unchanged");
        do_rd(2'd1, 8'h12, "R9 read does not step pointer");

        // R8 wrap 2047 -> 0
        do_wr(2'd0, 8'h47);
        do_wr(2'd1, 8'hFF);
        do_wr(2'd2, 8'hA5);
        do_wr(2'd2, 8'h3C);
        do_rd(2'd0, 8'h40, "R8 high bits wrapped");
        do_rd(2'd1, 8'h01, "R8 low bits after wrap");
        do_wr(2'd0, 8'hC7);
        do_wr(2'd1, 8'hFF);
        do_rd(2'd2, 8'hA5, "R8 top byte");
        do_rd(2'd2, 8'h3C, "R8 wrapped fetch of byte 0");
        do_rd(2'd0, 8'hC0, "R8 high after read wrap");
        do_rd(2'd1, 8'h01, "R8 low after read wrap");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_up();
    end
endmodule